// File: doc/BRIEF.md
# Quick-Move Execute and Flag Unit

This unit performs the register-move step of a 16-bit-opcode CISC core. A move begins when the start strobe is high. In that cycle the caller supplies four things: the opcode word, a class select, a size code and the source operand. For byte and word moves the caller also supplies the current contents of the destination register. One clock later the unit presents the 32-bit value to be written, the destination register index and a write enable. It also presents the N, Z, V and C condition flags together with their own update enable.

There are three classes of move:

- **Quick move.** The signed byte is taken from the low half of the opcode and widened to 32 bits.
- **Plain move.** The source is copied into a data register. Only the lanes selected by the size are replaced, and the flags are taken from that width.
- **Address move.** The value written to an address register is widened, and the condition flags are left alone.

Bus cycles, operand fetch and the extend flag are handled elsewhere in the core.

Top module: `qmove_exec`

## Requirements
- R1: Quick move (`op_class`=0). The result is `opcode[7:0]` sign-extended to 32 bits, whatever the size code. `wr_idx` is `opcode[11:9]` and `wr_addr` is 0.
- R2: Quick move flags. N equals `opcode[7]`. Z is 1 exactly when `opcode[7:0]` is zero.
- R3: Every flag-updating move (classes 0 and 1) clears V and C. `flag_we` is high in the result cycle.
- R4: Plain move (`op_class`=1) with `size`=0 (byte) replaces only bits 7:0 of `dst_old`. With `size`=1 (word) it replaces only bits 15:0. With `size`=2 or 3 (long) all 32 bits come from `src`. `wr_idx` is `opcode[11:9]` and `wr_addr` is 0.
- R5: Plain move flags follow the width. For byte, N is `src[7]` and Z is set when `src[7:0]` is zero. For word, N is `src[15]` and Z tests `src[15:0]`. For long, N is `src[31]` and Z tests all of `src`.
- R6: Address move (`op_class`=2). With `size`=2 or 3 the result is all 32 bits of `src`. With `size`=0 or 1 it is `src[15:0]` sign-extended. `wr_addr` is 1 and `wr_idx` is `opcode[11:9]`.
- R7: An address move keeps `flag_we` low and leaves all four flag outputs at their previous values.
- R8: `done` and `wr_en` rise exactly one clock after a start. Without a further start they last a single cycle. Starts on consecutive cycles give results on consecutive cycles.
- R9: Class code 3 is reserved. It pulses `done` but asserts neither `wr_en` nor `flag_we`, and the flags keep their values.
- R10: After reset `done`, `wr_en`, `flag_we`, `result` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move this cycle |
| op_class | input | 2 | 0 quick, 1 plain, 2 address, 3 reserved |
| size | input | 2 | 0 byte, 1 word, 2/3 long |
| opcode | input | 16 | Current opcode word |
| src | input | 32 | Source operand |
| dst_old | input | 32 | Present destination contents for partial writes |
| result | output | 32 | Value to write |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 3 | Destination register number |
| wr_addr | output | 1 | 1 selects the address register file |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| flag_we | output | 1 | Flag update strobe |
| done | output | 1 | Result-valid pulse |

## Verification
Two things share one clock edge: the result and flags of one move are registered at the same edge that accepts the next start. The bench provokes this by issuing moves on consecutive cycles, mixing flag-updating moves with address and reserved moves. After each address or reserved move it checks that the flags still hold the values left by the last quick or plain move. Each result is compared against a value recomputed arithmetically in the bench from the size, the class and the lane rules.

// File: rtl/qmove_exec.sv
module qmove_exec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op_class,
  input  logic [1:0]  size,
  input  logic [15:0] opcode,
  input  logic [31:0] src,
  input  logic [31:0] dst_old,
  output logic [31:0] result,
  output logic        wr_en,
  output logic [2:0]  wr_idx,
  output logic        wr_addr,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_v,
  output logic        flag_c,
  output logic        flag_we,
  output logic        done
);
  localparam logic [1:0] CL_QUICK = 2'd0;
  localparam logic [1:0] CL_PLAIN = 2'd1;
  localparam logic [1:0] CL_ADDR  = 2'd2;
  localparam logic [1:0] CL_RSV   = 2'd3;

  logic [31:0] nxt;
  logic        nn, nz;
  logic        sets_flags;
  logic [4:0]  unused_bits;

  assign unused_bits = {opcode[15:12], opcode[8]};
  assign sets_flags  = (op_class == CL_QUICK) || (op_class == CL_PLAIN);

  always_comb begin
    nxt = dst_old;
    nn  = 1'b0;
    nz  = 1'b0;
    case (op_class)
      CL_QUICK: begin
        nxt = {{24{opcode[7]}}, opcode[7:0]};
        nn  = opcode[7];
        nz  = (opcode[7:0] == 8'd0);
      end
      CL_PLAIN: begin
        case (size)
          2'd0: begin
            nxt = {dst_old[31:8], src[7:0]};
            nn  = src[7];
            nz  = (src[7:0] == 8'd0);
          end
          2'd1: begin
            nxt = {dst_old[31:16], src[15:0]};
            nn  = src[15];
            nz  = (src[15:0] == 16'd0);
          end
          default: begin
            nxt = src;
            nn  = src[31];
            nz  = (src == 32'd0);
          end
        endcase
      end
      CL_ADDR: nxt = size[1] ? src : {{16{src[15]}}, src[15:0]};
      default: nxt = dst_old;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_addr <= 1'b0;
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
      flag_v  <= 1'b0;
      flag_c  <= 1'b0;
      flag_we <= 1'b0;
      done    <= 1'b0;
    end else begin
      done    <= start;
      wr_en   <= start && (op_class != CL_RSV);
      flag_we <= start && sets_flags;
      if (start && op_class != CL_RSV) begin
        result  <= nxt;
        wr_idx  <= opcode[11:9];
        wr_addr <= (op_class == CL_ADDR);
      end
      if (start && sets_flags) begin
        flag_n <= nn;
        flag_z <= nz;
        flag_v <= 1'b0;
        flag_c <= 1'b0;
      end
    end
  end

  // R8
  start_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R3
  vc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (!flag_v && !flag_c));

  // R1
  quick_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_class == CL_QUICK) |=>
      (result == {{24{$past(opcode[7])}}, $past(opcode[7:0])}) && !wr_addr);

  // R2
  quick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_class == CL_QUICK) |=> (flag_z == (result == 32'd0)));

  // R7
  addr_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_class == CL_ADDR) |=>
      (!flag_we && $stable(flag_n) && $stable(flag_z) && $stable(flag_v) && $stable(flag_c)));

  // R9
  rsv_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_class == CL_RSV) |=> (done && !wr_en && !flag_we));
endmodule

// File: tb/qmove_exec_test.sv
`timescale 1ns/1ps
module qmove_exec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_class = '0;
  logic [1:0]  size = '0;
  logic [15:0] opcode = '0;
  logic [31:0] src = '0;
  logic [31:0] dst_old = '0;
  logic [31:0] result;
  logic        wr_en, wr_addr, flag_n, flag_z, flag_v, flag_c, flag_we, done;
  logic [2:0]  wr_idx;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit exp_n = 0, exp_z = 0;

  always #4 clk = ~clk;

  qmove_exec uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class), .size(size),
    .opcode(opcode), .src(src), .dst_old(dst_old), .result(result),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .flag_we(flag_we),
    .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sx8(input logic [7:0] b);
    return (b >= 8'd128) ? (32'(b) + 32'hFFFF_FF00) : 32'(b);
  endfunction
  function automatic logic [31:0] sx16(input logic [15:0] w);
    return (w >= 16'h8000) ? (32'(w) + 32'hFFFF_0000) : 32'(w);
  endfunction

  // Called at a negedge; drives one move and checks its result one clock later.
  task automatic run_op(input logic [1:0] cls, input logic [1:0] sz, input logic [15:0] op,
                        input logic [31:0] s, input logic [31:0] old);
    logic [31:0] er;
    logic [2:0] ei;
    bit en, ez, upd;
    er = 0; en = 0; ez = 0; upd = 0;
    ei = 3'((op >> 9) & 16'h7);
    case (cls)
      2'd0: begin er = sx8(op[7:0]); en = op[7:0] >= 8'd128; ez = op[7:0] == 0; upd = 1; end
      2'd1: begin
        upd = 1;
        if (sz == 0) begin er = (old & 32'hFFFF_FF00) | (s % 256); en = (s % 256) >= 128; ez = (s % 256) == 0; end
        else if (sz == 1) begin er = (old & 32'hFFFF_0000) | (s % 65536); en = (s % 65536) >= 32768; ez = (s % 65536) == 0; end
        else begin er = s; en = s >= 32'h8000_0000; ez = s == 0; end
      end
      2'd2: er = (sz >= 2) ? s : sx16(s[15:0]);
      default: er = 0;
    endcase
    if (upd) begin exp_n = en; exp_z = ez; end
    start = 1; op_class = cls; size = sz; opcode = op; src = s; dst_old = old;
    @(negedge clk);
    chk(done === 1'b1, "R8 done", 32'(done), 1);
    chk(wr_en === (cls != 3), (cls == 3) ? "R9 wr_en" : "R8 wr_en", 32'(wr_en), 32'(cls != 3));
    chk(flag_we === upd, (cls == 2) ? "R7 flag_we" : ((cls == 3) ? "R9 flag_we" : "R3 flag_we"), 32'(flag_we), 32'(upd));
    chk(flag_n === exp_n && flag_z === exp_z,
        (cls == 0) ? "R2 nz" : (cls == 1) ? "R5 nz" : (cls == 2) ? "R7 held" : "R9 held",
        {30'd0, flag_n, flag_z}, {30'd0, exp_n, exp_z});
    chk(!flag_v && !flag_c, "R3 vc", {30'd0, flag_v, flag_c}, 0);
    if (cls != 3) begin
      chk(result === er, (cls == 0) ? "R1 result" : (cls == 1) ? "R4 result" : "R6 result", result, er);
      chk(wr_idx === ei && wr_addr === (cls == 2), (cls == 2) ? "R6 idx" : "R1 idx",
          {28'd0, wr_addr, wr_idx}, {28'd0, 1'(cls == 2), ei});
    end
  endtask

  task automatic idle();
    start = 0;
    @(negedge clk);
    chk(!done && !wr_en && !flag_we, "R8 pulse", {29'd0, done, wr_en, flag_we}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(result === 0 && !done && !wr_en && !flag_we && !flag_n && !flag_z && !flag_v && !flag_c,
        "R10 reset", result, 0);
    rst_n = 1;
    @(negedge clk);
    for (int b = 0; b < 256; b++)
      run_op(2'd0, 2'(b % 3), 16'h7000 | 16'((b % 8) << 9) | 16'(b), 32'hDEAD_BEEF, 32'h1234_5678);
    idle();
    for (int sz = 0; sz < 4; sz++) begin
      for (int p = 0; p < 16; p++) begin
        logic [31:0] s;
        case (p)
          0: s = 0;            1: s = 1;            2: s = 32'h7F;        3: s = 32'h80;
          4: s = 32'hFF;       5: s = 32'h100;      6: s = 32'h7FFF;      7: s = 32'h8000;
          8: s = 32'hFFFF;     9: s = 32'h1_0000;   10: s = 32'h7FFF_FFFF; 11: s = 32'h8000_0000;
          12: s = 32'hFFFF_FFFF; 13: s = 32'h1234_5678; 14: s = 32'h00FF_0000; default: s = 32'hABCD_0080;
        endcase
        run_op(2'd1, 2'(sz), 16'h2000 | 16'((p % 8) << 9), s, ~s ^ 32'h5A5A_5A5A);
        run_op(2'd2, 2'(sz), 16'h3040 | 16'(((p + 3) % 8) << 9), s, 32'h0F0F_0F0F);
        run_op(2'd3, 2'(sz), 16'h0000, s, 0);
      end
      idle();
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule